// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This unit is one output-compare channel of a timer. It holds a compare value and checks it against the timer's count on every tick. The count comes from an external counter, along with that counter's direction, its TOP and BOTTOM indications and a note of when software writes it. From these inputs and a 2-bit output mode, the unit drives one waveform pin. What each output mode does depends on the waveform mode in use, which falls into one of three classes: plain counting (non-PWM), single-slope (fast) PWM, or dual-slope PWM. The unit also raises a match flag and a masked interrupt request.

The 4-bit waveform mode decides the class. Modes 5, 6, 7, 14 and 15 are fast PWM. Modes 1, 2, 3, 8, 9, 10 and 11 are dual-slope PWM. Every other value is non-PWM. Software can force a compare action without a real match, but only in the non-PWM class. The parameter `IS_CHAN_A` marks the one channel of a timer that may toggle while in a PWM class.

Top module: `cmp_wave_unit`

## Requirements
- R1: After reset release with `com` = 00, the outputs `pin_out`, `pin_override`, `pin_oe`, `match_flag` and `irq` are all 0.
- R2: In the non-PWM class, a match changes `pin_out` on the next clock according to `com`: 00 leaves it unchanged, 01 inverts it, 10 drives it to 0 and 11 drives it to 1.
- R3: In the fast class with `com` = 10, a match drives 0 and a tick with `at_bottom` drives 1. With `com` = 11 the two actions are swapped. If a match and BOTTOM fall on the same tick, the match action wins.
- R4: In the dual-slope class with `com` = 10, a match drives 0 while `cnt_down` = 0 and drives 1 while `cnt_down` = 1. With `com` = 11 the levels are inverted.
- R5: With `com` = 01 in a PWM class, a match inverts `pin_out` only on channel A and only for waveform modes 14, 15, 9 or 11. In every other case the pin is disconnected: `pin_override` is 0 and `pin_out` does not change.
- R6: In the fast class with `com[1]` = 1, a match on a tick where `at_top` = 1 is ignored. Only the BOTTOM action changes the pin.
- R7: A `force_stb` pulse applies the `com` action at once in the non-PWM class, whether or not a tick is present. It never sets `match_flag`. In a PWM class it has no effect.
- R8: `match_flag` becomes 1 one clock after a tick on which the count equals the compare value. It is cleared by `flag_clr` or `int_ack`, and a new match wins over a clear in the same cycle.
- R9: After a cycle with `cnt_wr` = 1, the next tick produces no match, so neither the pin nor the flag reacts to it.
- R10: `pin_override` is 1 when the pin is connected, meaning `com` is not 00 and the case in R5 does not apply. `pin_oe` is `pin_override` AND `dir_en`.
- R11: `irq` is the AND of `match_flag`, `irq_en` and `gie`.
- R12: A `cmp_wr` pulse loads `cmp_wdata` as the compare value. A matching count without `tick` causes no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer tick enable |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | Counter is counting down |
| at_top | input | 1 | Counter is at TOP |
| at_bottom | input | 1 | Counter is at BOTTOM |
| cnt_wr | input | 1 | Counter written this cycle |
| wgm | input | 4 | Waveform mode |
| com | input | 2 | Output mode |
| cmp_wr | input | 1 | Load the compare value |
| cmp_wdata | input | CNT_W | New compare value |
| force_stb | input | 1 | Force-compare strobe |
| dir_en | input | 1 | Pin direction bit |
| flag_clr | input | 1 | Write-one clear of the flag |
| int_ack | input | 1 | Interrupt acknowledge |
| irq_en | input | 1 | Local interrupt enable |
| gie | input | 1 | Global interrupt enable |
| pin_out | output | 1 | Waveform output |
| pin_override | output | 1 | Channel owns the pin |
| pin_oe | output | 1 | Pin driver enable |
| match_flag | output | 1 | Compare match flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong compare value or a stuck suppression bit shows up at the next matching tick. The flag then stays low, or `pin_out` misses its edge, one clock after that tick. A wrong class decode or a wrong direction rule shows up within one counter period, because the pin settles at the wrong level or the BOTTOM action appears where it should not. The bench runs a reference model alongside the design and compares every output on every clock, so any such divergence is reported in the first cycle it appears.

// File: rtl/cmp_wave_pkg.sv
// Package: shared encodings for the compare output waveform unit.
// Assumes a 4-bit waveform mode and a 2-bit output mode.
package cmp_wave_pkg;
    localparam int WGM_W = 4;
    localparam int COM_W = 2;

    typedef enum logic [1:0] {
        WAVE_NONPWM = 2'd0,
        WAVE_FAST   = 2'd1,
        WAVE_DUAL   = 2'd2
    } wave_class_e;

    typedef enum logic [COM_W-1:0] {
        OUT_OFF    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_LOW    = 2'b10,
        OUT_HIGH   = 2'b11
    } out_mode_e;

    // Map a waveform mode onto its class.
    function automatic wave_class_e classify_wgm(input logic [WGM_W-1:0] m);
        case (m)
            4'd5, 4'd6, 4'd7, 4'd14, 4'd15:                 return WAVE_FAST;
            4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11:     return WAVE_DUAL;
            default:                                        return WAVE_NONPWM;
        endcase
    endfunction

    // Waveform modes in which a PWM-class toggle is permitted.
    function automatic logic pwm_toggle_mode(input logic [WGM_W-1:0] m);
        return (m == 4'd14) || (m == 4'd15) || (m == 4'd9) || (m == 4'd11);
    endfunction
endpackage

// File: rtl/cmp_match_unit.sv
// Module: holds the compare value and produces the qualified match strobe.
// Assumes cnt_wr marks a cycle in which the external counter was written;
// the next tick after it must not produce a match.
module cmp_match_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic             hit
);
    logic [CNT_W-1:0] cmp_q;
    logic             blk_q;

    // Compare value storage, loaded from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= cmp_wdata;
    end

    // Suppression bit: armed by a counter write, consumed by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      blk_q <= 1'b0;
        else if (cnt_wr) blk_q <= 1'b1;
        else if (tick)   blk_q <= 1'b0;
    end

    assign hit = tick && !blk_q && (cnt_val == cmp_q);
endmodule

// File: rtl/cmp_flag_unit.sv
// Module: match flag with write-one clear, acknowledge clear and masked request.
// Assumes a set and a clear in the same cycle resolve to set.
module cmp_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic int_ack,
    input  logic irq_en,
    input  logic gie,
    output logic flag,
    output logic irq
);
    logic flag_q;

    // Flag register: set on match, cleared by software or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (hit)                   flag_q <= 1'b1;
        else if (flag_clr || int_ack)   flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en & gie;
endmodule

// File: rtl/cmp_wave_gen.sv
// Module: output register and the per-class action rules.
// Assumes hit already includes tick qualification and suppression.
module cmp_wave_gen
    import cmp_wave_pkg::*;
#(
    parameter bit IS_CHAN_A = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hit,
    input  logic             force_stb,
    input  logic             at_top,
    input  logic             at_bottom,
    input  logic             cnt_down,
    input  logic [COM_W-1:0] com,
    input  logic [WGM_W-1:0] wgm,
    output logic             oc,
    output logic             connected,
    output logic             is_pwm,
    output logic             is_fast
);
    wave_class_e wclass;
    logic        tog_ok;
    logic        oc_q;
    logic        oc_next;

    assign wclass = classify_wgm(wgm);

    // Only channel A may toggle in a PWM class.
    generate
        if (IS_CHAN_A) begin : g_tog_a
            assign tog_ok = pwm_toggle_mode(wgm);
        end else begin : g_tog_other
            assign tog_ok = 1'b0;
        end
    endgenerate

    // Next output level from class, mode and events.
    always_comb begin
        oc_next = oc_q;
        case (wclass)
            WAVE_NONPWM: begin
                if (hit || force_stb) begin
                    case (com)
                        OUT_TOGGLE: oc_next = ~oc_q;
                        OUT_LOW:    oc_next = 1'b0;
                        OUT_HIGH:   oc_next = 1'b1;
                        default:    oc_next = oc_q;
                    endcase
                end
            end
            WAVE_FAST: begin
                if (com == OUT_TOGGLE) begin
                    if (tog_ok && hit) oc_next = ~oc_q;
                end else if (com[1]) begin
                    if (hit && !at_top)          oc_next = com[0];
                    else if (tick && at_bottom)  oc_next = ~com[0];
                end
            end
            WAVE_DUAL: begin
                if (com == OUT_TOGGLE) begin
                    if (tog_ok && hit) oc_next = ~oc_q;
                end else if (com[1] && hit) begin
                    oc_next = com[0] ^ cnt_down;
                end
            end
            default: oc_next = oc_q;
        endcase
    end

    // Output register update.
    always_ff @(posedge clk) begin
        if (!rst_n) oc_q <= 1'b0;
        else        oc_q <= oc_next;
    end

    assign oc        = oc_q;
    assign is_pwm    = (wclass != WAVE_NONPWM);
    assign is_fast   = (wclass == WAVE_FAST);
    assign connected = (com != OUT_OFF) && !(is_pwm && (com == OUT_TOGGLE) && !tog_ok);
endmodule

// File: rtl/cmp_wave_unit.sv
// Module: top of one compare output channel; ties match, flag and waveform.
// Assumes the external counter supplies value, direction and TOP/BOTTOM strobes.
module cmp_wave_unit
    import cmp_wave_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit IS_CHAN_A = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             at_top,
    input  logic             at_bottom,
    input  logic             cnt_wr,
    input  logic [3:0]       wgm,
    input  logic [1:0]       com,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             force_stb,
    input  logic             dir_en,
    input  logic             flag_clr,
    input  logic             int_ack,
    input  logic             irq_en,
    input  logic             gie,
    output logic             pin_out,
    output logic             pin_override,
    output logic             pin_oe,
    output logic             match_flag,
    output logic             irq
);
    logic match_hit;
    logic is_pwm;
    logic is_fast;

    cmp_match_unit #(.CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cnt_val   (cnt_val),
        .cnt_wr    (cnt_wr),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .hit       (match_hit)
    );

    cmp_flag_unit u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (match_hit),
        .flag_clr (flag_clr),
        .int_ack  (int_ack),
        .irq_en   (irq_en),
        .gie      (gie),
        .flag     (match_flag),
        .irq      (irq)
    );

    cmp_wave_gen #(.IS_CHAN_A(IS_CHAN_A)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .hit       (match_hit),
        .force_stb (force_stb),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .cnt_down  (cnt_down),
        .com       (com),
        .wgm       (wgm),
        .oc        (pin_out),
        .connected (pin_override),
        .is_pwm    (is_pwm),
        .is_fast   (is_fast)
    );

    assign pin_oe = pin_override & dir_en;
endmodule

// File: rtl/cmp_wave_unit_chk.sv
// Module: temporal checks on the compare output channel, bound to the top.
// Assumes the bench holds all pulse inputs low during reset.
module cmp_wave_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       cnt_wr,
    input logic       at_top,
    input logic       at_bottom,
    input logic [1:0] com,
    input logic       match_hit,
    input logic       is_pwm,
    input logic       is_fast,
    input logic       match_flag,
    input logic       pin_out
);
    AST_FLAG_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> match_flag); // R8
    AST_FLAG_ONLY_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(match_hit)); // R7
    AST_WRITE_BLOCKS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_wr) && tick) |-> !match_hit); // R9
    AST_DISCONNECTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (com == 2'b00) |=> $stable(pin_out)); // R2
    AST_PWM_IGNORES_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && !tick) |=> $stable(pin_out)); // R7
    AST_FAST_TOP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fast && com[1] && at_top && tick && !at_bottom) |=> $stable(pin_out)); // R6
endmodule

bind cmp_wave_unit cmp_wave_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cnt_wr     (cnt_wr),
    .at_top     (at_top),
    .at_bottom  (at_bottom),
    .com        (com),
    .match_hit  (match_hit),
    .is_pwm     (is_pwm),
    .is_fast    (is_fast),
    .match_flag (match_flag),
    .pin_out    (pin_out)
);

// File: tb/cmp_wave_unit_tb.sv
module cmp_wave_unit_tb;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] cnt_val = '0;
    logic          cnt_down = 1'b0;
    logic          at_top = 1'b0;
    logic          at_bottom = 1'b0;
    logic          cnt_wr = 1'b0;
    logic [3:0]    wgm = 4'd0;
    logic [1:0]    com = 2'b00;
    logic          cmp_wr = 1'b0;
    logic [CW-1:0] cmp_wdata = '0;
    logic          force_stb = 1'b0;
    logic          dir_en = 1'b1;
    logic          flag_clr = 1'b0;
    logic          int_ack = 1'b0;
    logic          irq_en = 1'b1;
    logic          gie = 1'b1;
    logic          pin_out, pin_override, pin_oe, match_flag, irq;

    cmp_wave_unit #(.CNT_W(CW), .IS_CHAN_A(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
        .cnt_down(cnt_down), .at_top(at_top), .at_bottom(at_bottom),
        .cnt_wr(cnt_wr), .wgm(wgm), .com(com), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .force_stb(force_stb), .dir_en(dir_en),
        .flag_clr(flag_clr), .int_ack(int_ack), .irq_en(irq_en), .gie(gie),
        .pin_out(pin_out), .pin_override(pin_override), .pin_oe(pin_oe),
        .match_flag(match_flag), .irq(irq)
    );

    always #5ns clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state.
    bit          m_oc = 0, m_blk = 0, m_flag = 0;
    int          m_cmp = 0;
    // Stimulus counter.
    int          tb_cnt = 0, tb_top = 9;
    bit          tb_down = 0;

    function automatic int wclass(int w);
        if (w == 5 || w == 6 || w == 7 || w == 14 || w == 15) return 1;
        if ((w >= 1 && w <= 3) || (w >= 8 && w <= 11)) return 2;
        return 0;
    endfunction

    function automatic bit tog_ok(int w);
        return (w == 14 || w == 15 || w == 9 || w == 11);
    endfunction

    task automatic check_bit(string name, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0b exp=%0b", cur_req, name, act, exp);
        end
    endtask

    task automatic check_all();
        bit conn;
        conn = (com != 0) && !(wclass(int'(wgm)) != 0 && com == 2'b01 && !tog_ok(int'(wgm)));
        check_bit("pin_out", pin_out, m_oc);
        check_bit("pin_override", pin_override, conn);
        check_bit("pin_oe", pin_oe, conn & dir_en);
        check_bit("match_flag", match_flag, m_flag);
        check_bit("irq", irq, m_flag & irq_en & gie);
    endtask

    // One clock: present counter, predict, clock, compare, advance.
    task automatic cycle(bit do_tick);
        bit hit, n_oc, n_blk, n_flag;
        int wc, n_cmp;
        tick      = do_tick;
        cnt_val   = CW'(tb_cnt);
        at_top    = (tb_cnt == tb_top);
        at_bottom = (tb_cnt == 0);
        cnt_down  = tb_down;
        wc = wclass(int'(wgm));
        hit = tick && !m_blk && (tb_cnt == m_cmp);
        n_oc = m_oc;
        if (wc == 0) begin
            if (hit || force_stb) begin
                if (com == 2'b01) n_oc = !m_oc;
                else if (com == 2'b10) n_oc = 0;
                else if (com == 2'b11) n_oc = 1;
            end
        end else if (com == 2'b01) begin
            if (tog_ok(int'(wgm)) && hit) n_oc = !m_oc;
        end else if (com[1]) begin
            if (wc == 1) begin
                if (hit && !at_top) n_oc = com[0];
                else if (tick && at_bottom) n_oc = !com[0];
            end else if (hit) begin
                n_oc = tb_down ? !com[0] : com[0];
            end
        end
        n_blk  = cnt_wr ? 1 : (tick ? 0 : m_blk);
        n_flag = hit ? 1 : ((flag_clr || int_ack) ? 0 : m_flag);
        n_cmp  = cmp_wr ? int'(cmp_wdata) : m_cmp;
        @(posedge clk);
        @(negedge clk);
        m_oc = n_oc; m_blk = n_blk; m_flag = n_flag; m_cmp = n_cmp;
        tick = 0; cnt_wr = 0; cmp_wr = 0; force_stb = 0; flag_clr = 0; int_ack = 0;
        check_all();
        if (do_tick) begin
            if (wc == 2) begin
                if (!tb_down) begin
                    if (tb_cnt == tb_top) begin tb_down = 1; tb_cnt--; end
                    else tb_cnt++;
                end else begin
                    if (tb_cnt == 0) begin tb_down = 0; tb_cnt++; end
                    else tb_cnt--;
                end
            end else begin
                tb_cnt = (tb_cnt == tb_top) ? 0 : tb_cnt + 1;
            end
        end
    endtask

    task automatic run(int n, int gap);
        for (int i = 0; i < n; i++) begin
            cycle(1);
            for (int g = 0; g < gap; g++) cycle(0);
        end
    endtask

    task automatic set_cmp(int v);
        cmp_wr = 1; cmp_wdata = CW'(v);
        cycle(0);
    endtask

    task automatic set_mode(int w, int c);
        wgm = 4'(w); com = 2'(c); tb_cnt = 0; tb_down = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2ms;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        check_all();
        rst_n = 1;
        cycle(0);

        // R12: load compare, no match without tick
        cur_req = "R12";
        set_cmp(5);
        set_mode(0, 3);
        tb_cnt = 5;
        cycle(0); cycle(0); cycle(0);
        cycle(1);

        // R2: non-PWM actions
        cur_req = "R2";
        set_mode(0, 1); run(25, 0);
        set_mode(4, 2); run(12, 1);
        set_mode(12, 3); run(12, 0);
        set_mode(0, 0); run(12, 0);

        // R8: flag clears and set-over-clear
        cur_req = "R8";
        set_mode(0, 1);
        for (int i = 0; i < 40; i++) begin
            flag_clr = (i % 3 == 0);
            int_ack  = (i % 7 == 0);
            cycle(1);
        end

        // R11: interrupt gating
        cur_req = "R11";
        for (int k = 0; k < 4; k++) begin
            irq_en = k[0]; gie = k[1];
            run(8, 0);
        end
        irq_en = 1; gie = 1;

        // R9: counter write suppresses next tick
        cur_req = "R9";
        set_mode(0, 1);
        cnt_wr = 1; cycle(1); tb_cnt = 5; cycle(1);
        run(6, 0);
        cnt_wr = 1; cycle(0); tb_cnt = 5; cycle(0); cycle(1);
        run(6, 0);

        // R7: force in non-PWM and in PWM
        cur_req = "R7";
        flag_clr = 1; cycle(0);
        set_mode(0, 1); tb_cnt = 2;
        for (int i = 0; i < 3; i++) begin force_stb = 1; cycle(0); end
        com = 2'b10; force_stb = 1; cycle(0);
        com = 2'b11; force_stb = 1; cycle(0);
        com = 2'b10; force_stb = 1; cycle(1);
        set_mode(14, 3);
        for (int i = 0; i < 4; i++) begin force_stb = 1; cycle(0); end

        // R3: fast PWM set/clear, match over bottom
        cur_req = "R3";
        set_mode(14, 2); run(25, 0);
        set_mode(14, 3); run(25, 1);
        set_mode(5, 2); run(12, 0);
        set_mode(7, 3); run(12, 0);
        set_cmp(0);
        set_mode(6, 2); run(22, 0);
        set_cmp(5);

        // R6: compare equal to TOP in fast PWM
        cur_req = "R6";
        set_cmp(9);
        set_mode(14, 2); run(25, 0);
        set_mode(15, 3); run(25, 0);
        set_cmp(5);

        // R5: PWM toggle permission
        cur_req = "R5";
        set_mode(14, 1); run(22, 0);
        set_mode(15, 1); run(22, 0);
        set_mode(5, 1);  run(22, 0);
        set_mode(9, 1);  run(40, 0);
        set_mode(11, 1); run(40, 0);
        set_mode(1, 1);  run(40, 0);

        // R4: dual-slope direction rules
        cur_req = "R4";
        set_cmp(4);
        set_mode(10, 2); run(40, 0);
        set_mode(10, 3); run(40, 1);
        set_mode(1, 2);  run(40, 0);

        // R10: pin enable follows direction bit
        cur_req = "R10";
        set_mode(0, 2);
        dir_en = 0; run(12, 0);
        dir_en = 1; run(4, 0);
        set_mode(0, 0); run(4, 0);

        done = 1;
        finish_run();
    end
endmodule